// File: doc/BRIEF.md
# Bus Performance Event Counter Unit

This unit watches one bus port and measures its activity. Two per-cycle strobes come in from the port: one for each read data beat and one for each write data beat. The unit keeps a free-running cycle counter and four event counters. Software reaches every register through a simple 32-bit register port. Writes take effect on the clock edge. A read returns its data one cycle after the read strobe, together with a valid pulse.

Each event counter picks what it counts through its own event-type register. Code 0x4 counts read beats and code 0x5 counts write beats. Code 0x22 counts both kinds of beat, and only counter 3 honours it. Counters 0 to 2 are `EVT_W` bits wide (32 by default). Counter 3 is `WIDE_W` bits wide (40 by default) and is read as a low word and a high word.

A two-state run machine gates all counting. Its states are HALT and RUN. The GO transition, from HALT to RUN, is taken when software writes the control register with the enable bit at 1 and the start-mode field at manual (0). The STOP transition, from RUN to HALT, is taken on any other control write. A control write with the enable bit at 1 and a non-manual mode sends the machine to HALT. Each counter has its own enable bit. Enable bits are set and cleared through separate write-one registers. Each counter has a sticky flag that records a wrap.

Top module: `perfmon_top`

## Requirements
- R1: After reset, every counter, enable, flag, event type and control field is 0, and every register reads back 0.
- R2: A read strobe returns data one cycle later with `reg_rvalid` high, and `reg_rvalid` is low in every cycle that follows no read strobe. The read offsets are:
  - 0x34, 0x38 and 0x3C: event counters 0, 1 and 2.
  - 0x40: bits 31:0 of counter 3.
  - 0x44: bits 39:32 of counter 3 in bits 7:0, zero when `WIDE_W` is 32 or less.
  - 0x48: the cycle counter.
  - 0x200 + 4·n: the event type of counter n, in bits 7:0.
- R3: Enable mask layout: bit 31 is the cycle counter, and bits 3:0 are event counters 3 to 0. Writing a 1 at 0x08 sets that enable bit and writing a 1 at 0x0C clears it. A 0 bit leaves the enable unchanged. Both offsets read back the current mask. A counter whose enable bit is 0 holds its value.
- R4: The control register is at 0x04. Its fields are: bit 0 global enable, bit 1 event-counter reset, bit 2 cycle-counter reset, bit 3 divider, and bits 21:20 start mode. The GO and STOP transitions work as described above. In HALT no counter changes, except through a reset.
- R5: In RUN, an enabled counter with code 0x4 adds 1 in each cycle that `rd_beat` is high. With code 0x5 it adds 1 in each cycle that `wr_beat` is high.
- R6: Counter 3 with code 0x22 adds the number of beats in the cycle, which is 0, 1 or 2. Counters 0 to 2 never count under code 0x22 or under any code other than 0x4 and 0x5.
- R7: Control bits 1 and 2 are one-cycle pulses. In the cycle of the control write, bit 1 clears all event counters, and bit 2 clears the cycle counter and its prescaler. Both bits always read back as 0. A clear wins over an increment in the same cycle.
- R8: Writing at 0x2C clears each counter whose bit is 1 in the enable mask layout.
- R9: When a counter wraps past its all-ones value, its flag is set in the flag register at 0x18, which uses the enable mask layout. A flag stays set until a 1 is written to its bit at 0x18. A wrap wins over a clear in the same cycle.
- R10: In RUN with bit 31 enabled, the cycle counter adds 1 on every clock when the divider bit is 0. When the divider bit is 1, it adds 1 once every 64 counted clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wen | input | 1 | Register write strobe |
| reg_ren | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid, one cycle after reg_ren |
| rd_beat | input | 1 | Read data beat seen on the watched port this cycle |
| wr_beat | input | 1 | Write data beat seen on the watched port this cycle |

## Verification
The hardest situation to reach from the ports is a counter wrap. A full-width counter would need billions of beats before it wrapped. The bench therefore builds the unit with narrow widths: 8-bit event counters, a 10-bit counter 3 and a 12-bit cycle counter. It then drives runs of 256, 512 and 4096 cycles, so that each counter lands exactly on zero and raises its flag.

Two further corners are reached through the register port.
- A control reset and a read beat land in the same cycle while the unit is running, which checks that the clear wins.
- A control write sets the enable bit with a non-manual start mode, which checks that the unit stays halted.

// File: rtl/perfmon_pkg.sv
package perfmon_pkg;
    localparam int ADDR_W   = 12;
    localparam int NUM_EV   = 4;
    localparam int DIV_LOG2 = 6;
    localparam int CYC_BIT  = 31;

    localparam logic [ADDR_W-1:0] OFF_CTRL   = 12'h004;
    localparam logic [ADDR_W-1:0] OFF_EN_SET = 12'h008;
    localparam logic [ADDR_W-1:0] OFF_EN_CLR = 12'h00C;
    localparam logic [ADDR_W-1:0] OFF_FLAG   = 12'h018;
    localparam logic [ADDR_W-1:0] OFF_CRST   = 12'h02C;
    localparam logic [ADDR_W-1:0] OFF_EV0    = 12'h034;
    localparam logic [ADDR_W-1:0] OFF_EV1    = 12'h038;
    localparam logic [ADDR_W-1:0] OFF_EV2    = 12'h03C;
    localparam logic [ADDR_W-1:0] OFF_EV3_LO = 12'h040;
    localparam logic [ADDR_W-1:0] OFF_EV3_HI = 12'h044;
    localparam logic [ADDR_W-1:0] OFF_CYC    = 12'h048;
    localparam logic [7:0]        EVT_PAGE   = 8'h20;

    localparam logic [7:0] CODE_RD = 8'h04;
    localparam logic [7:0] CODE_WR = 8'h05;
    localparam logic [7:0] CODE_RW = 8'h22;

    typedef enum logic [0:0] {
        ST_HALT = 1'b0,
        ST_RUN  = 1'b1
    } run_state_t;
endpackage

// File: rtl/pm_event_ctr.sv
module pm_event_ctr
    import perfmon_pkg::*;
#(
    parameter int W        = 32,
    parameter bit ALLOW_RW = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         count_ok,
    input  logic [7:0]   code,
    input  logic         rd_beat,
    input  logic         wr_beat,
    output logic [W-1:0] value,
    output logic         wrap
);
    logic [1:0] step;
    logic [W:0] sum;

    always_comb begin
        unique case (code)
            CODE_RD: step = {1'b0, rd_beat};
            CODE_WR: step = {1'b0, wr_beat};
            CODE_RW: step = ALLOW_RW ? (2'(rd_beat) + 2'(wr_beat)) : 2'd0;
            default: step = 2'd0;
        endcase
        sum  = {1'b0, value} + (W+1)'(step);
        wrap = count_ok && !clr && sum[W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        value <= '0;
        else if (clr)      value <= '0;
        else if (count_ok) value <= sum[W-1:0];
    end
endmodule

// File: rtl/pm_cycle_ctr.sv
module pm_cycle_ctr
    import perfmon_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         count_ok,
    input  logic         div,
    output logic [W-1:0] value,
    output logic         wrap
);
    logic [DIV_LOG2-1:0] pre;
    logic                tick;

    always_comb begin
        tick = count_ok && (!div || (pre == '1));
        wrap = tick && !clr && (value == '1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre   <= '0;
            value <= '0;
        end else if (clr) begin
            pre   <= '0;
            value <= '0;
        end else begin
            if (count_ok && div) pre <= pre + 1'b1;
            if (tick) value <= value + 1'b1;
        end
    end
endmodule

// File: rtl/pm_ctrl.sv
module pm_ctrl
    import perfmon_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wen,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [31:0]       wdata,
    input  logic [NUM_EV-1:0] ev_wrap,
    input  logic              cyc_wrap,
    output logic              run,
    output logic              ctrl_en,
    output logic [1:0]        mode,
    output logic              div,
    output logic [31:0]       en_mask,
    output logic [31:0]       flag_mask,
    output logic [NUM_EV-1:0] ev_clr,
    output logic              cyc_clr
);
    run_state_t        state, state_nx;
    logic [NUM_EV-1:0] ev_en, ev_flag;
    logic              cyc_en, cyc_flag;
    logic              wr_ctrl, wr_set, wr_clr, wr_flag, wr_crst;

    always_comb begin
        wr_ctrl = wen && (waddr == OFF_CTRL);
        wr_set  = wen && (waddr == OFF_EN_SET);
        wr_clr  = wen && (waddr == OFF_EN_CLR);
        wr_flag = wen && (waddr == OFF_FLAG);
        wr_crst = wen && (waddr == OFF_CRST);
    end

    // Run machine: GO on a manual-mode enabling write, STOP on any other control write
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_HALT: if (wr_ctrl && wdata[0] && (wdata[21:20] == 2'd0)) state_nx = ST_RUN;
            ST_RUN:  if (wr_ctrl && !(wdata[0] && (wdata[21:20] == 2'd0))) state_nx = ST_HALT;
            default: state_nx = ST_HALT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_HALT;
        else        state <= state_nx;
    end

    always_comb begin
        run     = (state == ST_RUN);
        ev_clr  = {NUM_EV{wr_ctrl && wdata[1]}} | ({NUM_EV{wr_crst}} & wdata[NUM_EV-1:0]);
        cyc_clr = (wr_ctrl && wdata[2]) || (wr_crst && wdata[CYC_BIT]);
        en_mask   = '0;
        flag_mask = '0;
        en_mask[NUM_EV-1:0]   = ev_en;
        en_mask[CYC_BIT]      = cyc_en;
        flag_mask[NUM_EV-1:0] = ev_flag;
        flag_mask[CYC_BIT]    = cyc_flag;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_en  <= 1'b0;
            mode     <= 2'd0;
            div      <= 1'b0;
            ev_en    <= '0;
            cyc_en   <= 1'b0;
            ev_flag  <= '0;
            cyc_flag <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                ctrl_en <= wdata[0];
                div     <= wdata[3];
                mode    <= wdata[21:20];
            end
            if (wr_set) begin
                ev_en  <= ev_en | wdata[NUM_EV-1:0];
                cyc_en <= cyc_en | wdata[CYC_BIT];
            end else if (wr_clr) begin
                ev_en  <= ev_en & ~wdata[NUM_EV-1:0];
                cyc_en <= cyc_en & ~wdata[CYC_BIT];
            end
            ev_flag  <= (ev_flag & ~({NUM_EV{wr_flag}} & wdata[NUM_EV-1:0])) | ev_wrap;
            cyc_flag <= (cyc_flag & ~(wr_flag && wdata[CYC_BIT])) | cyc_wrap;
        end
    end
endmodule

// File: rtl/perfmon_top.sv
module perfmon_top
    import perfmon_pkg::*;
#(
    parameter int EVT_W  = 32,
    parameter int WIDE_W = 40,
    parameter int CYC_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wen,
    input  logic              reg_ren,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              reg_rvalid,
    input  logic              rd_beat,
    input  logic              wr_beat
);
    logic              run, ctrl_en, div, cyc_clr, cyc_wrap;
    logic [1:0]        mode;
    logic [31:0]       en_mask, flag_mask;
    logic [NUM_EV-1:0] ev_clr, ev_wrap;
    logic [7:0]        ev_code [NUM_EV];
    logic [63:0]       ev_ext  [NUM_EV];
    logic [63:0]       cyc_ext;
    logic [CYC_W-1:0]  cyc_val;
    logic [31:0]       rd_next;
    logic              evt_hit;

    pm_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wen       (reg_wen),
        .waddr     (reg_addr),
        .wdata     (reg_wdata),
        .ev_wrap   (ev_wrap),
        .cyc_wrap  (cyc_wrap),
        .run       (run),
        .ctrl_en   (ctrl_en),
        .mode      (mode),
        .div       (div),
        .en_mask   (en_mask),
        .flag_mask (flag_mask),
        .ev_clr    (ev_clr),
        .cyc_clr   (cyc_clr)
    );

    assign evt_hit = (reg_addr[ADDR_W-1:4] == EVT_PAGE) && (reg_addr[1:0] == 2'b00);

    for (genvar i = 0; i < NUM_EV; i++) begin : g_ev
        localparam int  CW  = (i == NUM_EV-1) ? WIDE_W : EVT_W;
        localparam bit  ARW = (i == NUM_EV-1);
        logic [CW-1:0] val;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                ev_code[i] <= '0;
            else if (reg_wen && evt_hit && (reg_addr[3:2] == 2'(i)))
                ev_code[i] <= reg_wdata[7:0];
        end

        pm_event_ctr #(.W(CW), .ALLOW_RW(ARW)) u_ctr (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (ev_clr[i]),
            .count_ok (run && en_mask[i]),
            .code     (ev_code[i]),
            .rd_beat  (rd_beat),
            .wr_beat  (wr_beat),
            .value    (val),
            .wrap     (ev_wrap[i])
        );
        assign ev_ext[i] = 64'(val);
    end

    pm_cycle_ctr #(.W(CYC_W)) u_cyc (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (cyc_clr),
        .count_ok (run && en_mask[CYC_BIT]),
        .div      (div),
        .value    (cyc_val),
        .wrap     (cyc_wrap)
    );
    assign cyc_ext = 64'(cyc_val);

    always_comb begin
        rd_next = '0;
        if (evt_hit) begin
            rd_next = {24'd0, ev_code[reg_addr[3:2]]};
        end else begin
            unique case (reg_addr)
                OFF_CTRL:   rd_next = {10'd0, mode, 16'd0, div, 2'b00, ctrl_en};
                OFF_EN_SET: rd_next = en_mask;
                OFF_EN_CLR: rd_next = en_mask;
                OFF_FLAG:   rd_next = flag_mask;
                OFF_EV0:    rd_next = ev_ext[0][31:0];
                OFF_EV1:    rd_next = ev_ext[1][31:0];
                OFF_EV2:    rd_next = ev_ext[2][31:0];
                OFF_EV3_LO: rd_next = ev_ext[3][31:0];
                OFF_EV3_HI: rd_next = {24'd0, ev_ext[3][39:32]};
                OFF_CYC:    rd_next = cyc_ext[31:0];
                default:    rd_next = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_rdata  <= '0;
            reg_rvalid <= 1'b0;
        end else begin
            reg_rvalid <= reg_ren;
            if (reg_ren) reg_rdata <= rd_next;
        end
    end
endmodule

// File: rtl/perfmon_checker.sv
module perfmon_checker
    import perfmon_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wen,
    input logic              reg_ren,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [31:0]       reg_wdata,
    input logic [31:0]       reg_rdata,
    input logic              reg_rvalid,
    input logic              run,
    input logic              ctrl_en,
    input logic [1:0]        mode,
    input logic [31:0]       flag_mask,
    input logic [NUM_EV-1:0] ev_wrap,
    input logic              cyc_wrap,
    input logic [NUM_EV-1:0] ev_clr,
    input logic              cyc_clr,
    input logic [63:0]       c0,
    input logic [63:0]       cyc
);
    // R2: read data valid follows the strobe by one cycle
    a_r2_rvalid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        reg_ren |=> reg_rvalid);
    a_r2_rvalid_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_ren |=> !reg_rvalid);

    // R4: running only with global enable in manual mode
    a_r4_run_manual: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (ctrl_en && mode == 2'd0));

    // R4: halted counter holds
    a_r4_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !ev_clr[0]) |=> (c0 == $past(c0)));

    // R7: pulse bits read back as zero
    a_r7_pulse_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_ren && reg_addr == OFF_CTRL) |=> (reg_rdata[2:1] == 2'b00));

    // R9: wrap raises the flag, flag is sticky
    a_r9_wrap_flags_ev0: assert property (@(posedge clk) disable iff (!rst_n)
        ev_wrap[0] |=> flag_mask[0]);
    a_r9_wrap_flags_cyc: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_wrap |=> flag_mask[CYC_BIT]);
    a_r9_flag0_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_mask[0] && !(reg_wen && reg_addr == OFF_FLAG && reg_wdata[0])) |=> flag_mask[0]);
    a_r9_flag31_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_mask[CYC_BIT] && !(reg_wen && reg_addr == OFF_FLAG && reg_wdata[CYC_BIT]))
        |=> flag_mask[CYC_BIT]);

    // R10: cycle counter moves by at most one per clock outside clears and wraps
    a_r10_cycle_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!cyc_clr && !cyc_wrap) |=> ((cyc - $past(cyc)) <= 64'd1));
endmodule

bind perfmon_top perfmon_checker u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wen    (reg_wen),
    .reg_ren    (reg_ren),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .reg_rvalid (reg_rvalid),
    .run        (run),
    .ctrl_en    (ctrl_en),
    .mode       (mode),
    .flag_mask  (flag_mask),
    .ev_wrap    (ev_wrap),
    .cyc_wrap   (cyc_wrap),
    .ev_clr     (ev_clr),
    .cyc_clr    (cyc_clr),
    .c0         (ev_ext[0]),
    .cyc        (cyc_ext)
);

// File: tb/perfmon_top_test.sv
module perfmon_top_test;
    import perfmon_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wen = 1'b0, reg_ren = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        reg_rvalid;
    logic        rd_beat = 1'b0, wr_beat = 1'b0;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    perfmon_top #(.EVT_W(8), .WIDE_W(10), .CYC_W(12)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_ren(reg_ren),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .reg_rvalid(reg_rvalid), .rd_beat(rd_beat), .wr_beat(wr_beat)
    );

    // Monitor: pop the expected item when the read data appears
    always @(negedge clk) begin
        if (rst_n && reg_rvalid) begin
            item_t it;
            tests++;
            if (sb.size() == 0) begin
                fails++;
                $display("FAIL R2 unexpected read data: actual %h expected none", reg_rdata);
            end else begin
                it = sb.pop_front();
                if (reg_rdata !== it.exp) begin
                    fails++;
                    $display("FAIL %s: actual %h expected %h", it.tag, reg_rdata, it.exp);
                end
            end
        end
    end

    task automatic drive(bit w, bit r, logic [11:0] a, logic [31:0] d, bit rb, bit wb);
        @(negedge clk);
        reg_wen = w; reg_ren = r; reg_addr = a; reg_wdata = d;
        rd_beat = rb; wr_beat = wb;
    endtask

    task automatic wr_reg(logic [11:0] a, logic [31:0] d, bit rb = 1'b0);
        drive(1'b1, 1'b0, a, d, rb, 1'b0);
    endtask

    task automatic rd_chk(logic [11:0] a, logic [31:0] e, string tag);
        item_t it;
        it.exp = e; it.tag = tag;
        sb.push_back(it);
        drive(1'b0, 1'b1, a, '0, 1'b0, 1'b0);
    endtask

    task automatic beats(int n, bit rb, bit wb);
        for (int i = 0; i < n; i++) drive(1'b0, 1'b0, '0, '0, rb, wb);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int nrd = 0, nwr = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd_chk(OFF_CTRL,   32'h0, "R1 ctrl after reset");
        rd_chk(OFF_EN_SET, 32'h0, "R1 enables after reset");
        rd_chk(OFF_EV0,    32'h0, "R1 counter0 after reset");
        rd_chk(OFF_CYC,    32'h0, "R1 cycle after reset");
        rd_chk(OFF_FLAG,   32'h0, "R1 flags after reset");
        rd_chk(12'h20C,    32'h0, "R1 event type 3 after reset");

        // R2 event types, R3 enables
        wr_reg(12'h200, 32'h04);
        wr_reg(12'h204, 32'h05);
        wr_reg(12'h208, 32'h22);
        wr_reg(12'h20C, 32'h22);
        rd_chk(12'h204, 32'h05, "R2 event type 1 readback");
        wr_reg(OFF_EN_SET, 32'h8000_000F);
        rd_chk(OFF_EN_CLR, 32'h8000_000F, "R3 set mask via clear offset");
        wr_reg(OFF_EN_CLR, 32'h0);
        rd_chk(OFF_EN_SET, 32'h8000_000F, "R3 zero clear write no effect");

        // R5 R6 R10 mixed pattern, 10 cycles
        wr_reg(OFF_CTRL, 32'h7);
        for (int i = 0; i < 10; i++) begin
            beats(1, (i % 2) == 0, (i % 3) == 0);
            if ((i % 2) == 0) nrd++;
            if ((i % 3) == 0) nwr++;
        end
        wr_reg(OFF_CTRL, 32'h0);
        rd_chk(OFF_EV0,    32'(nrd),       "R5 read beat count");
        rd_chk(OFF_EV1,    32'(nwr),       "R5 write beat count");
        rd_chk(OFF_EV2,    32'h0,          "R6 code 0x22 ignored on counter2");
        rd_chk(OFF_EV3_LO, 32'(nrd + nwr), "R6 combined count on counter3");
        rd_chk(OFF_EV3_HI, 32'h0,          "R2 counter3 high word");
        rd_chk(OFF_CYC,    32'd11,         "R10 cycle count every clock");

        // R4 halted: beats ignored
        beats(5, 1'b1, 1'b1);
        rd_chk(OFF_EV0, 32'd5, "R4 halt ignores beats");

        // R4 non-manual mode stays halted
        wr_reg(OFF_CTRL, 32'h0010_0001);
        rd_chk(OFF_CTRL, 32'h0010_0001, "R4 ctrl mode readback");
        beats(4, 1'b1, 1'b0);
        wr_reg(OFF_CTRL, 32'h0);
        rd_chk(OFF_EV0, 32'd5, "R4 auto mode does not count");

        // R3 disable counter1
        wr_reg(OFF_EN_CLR, 32'h2);
        rd_chk(OFF_EN_SET, 32'h8000_000D, "R3 clear one enable");
        wr_reg(OFF_CTRL, 32'h1);
        beats(3, 1'b1, 1'b1);
        wr_reg(OFF_CTRL, 32'h0);
        rd_chk(OFF_EV0,    32'd8,  "R5 counter0 resumes");
        rd_chk(OFF_EV1,    32'd4,  "R3 disabled counter holds");
        rd_chk(OFF_EV3_LO, 32'd15, "R6 counter3 adds two per cycle");
        rd_chk(OFF_CYC,    32'd15, "R10 cycle continues");

        // R8 counter reset register
        wr_reg(OFF_CRST, 32'h8000_0001);
        rd_chk(OFF_EV0,    32'd0,  "R8 counter0 cleared");
        rd_chk(OFF_CYC,    32'd0,  "R8 cycle cleared");
        rd_chk(OFF_EV3_LO, 32'd15, "R8 unselected counter3 kept");

        // R7 reset pulse wins over a beat while running
        wr_reg(OFF_CTRL, 32'h1);
        beats(2, 1'b1, 1'b0);
        wr_reg(OFF_CTRL, 32'h3, 1'b1);
        rd_chk(OFF_CTRL, 32'h1, "R7 reset bit reads zero");
        wr_reg(OFF_CTRL, 32'h0);
        rd_chk(OFF_EV0,    32'd0, "R7 clear beats increment counter0");
        rd_chk(OFF_EV3_LO, 32'd0, "R7 clear reaches counter3");
        rd_chk(OFF_CYC,    32'd5, "R7 bit1 leaves cycle counter");

        // R9 counter0 wrap (8 bits)
        wr_reg(OFF_CTRL, 32'h7);
        beats(256, 1'b1, 1'b0);
        wr_reg(OFF_CTRL, 32'h0);
        rd_chk(OFF_EV0,    32'd0,   "R9 counter0 wrapped to zero");
        rd_chk(OFF_EV3_LO, 32'd256, "R6 counter3 read-only beats");
        rd_chk(OFF_FLAG,   32'h1,   "R9 counter0 flag set");
        rd_chk(OFF_FLAG,   32'h1,   "R9 flag sticky");
        wr_reg(OFF_FLAG, 32'h1);
        rd_chk(OFF_FLAG,   32'h0,   "R9 flag cleared by write one");

        // R9 counter3 wrap by double steps (10 bits)
        wr_reg(OFF_CTRL, 32'h7);
        beats(512, 1'b1, 1'b1);
        wr_reg(OFF_CTRL, 32'h0);
        rd_chk(OFF_EV3_LO, 32'd0, "R9 counter3 wrapped");
        rd_chk(OFF_FLAG,   32'h9, "R9 counter3 and counter0 flags");
        wr_reg(OFF_FLAG, 32'h9);
        rd_chk(OFF_FLAG,   32'h0, "R9 both flags cleared");

        // R10 divider
        wr_reg(OFF_CTRL, 32'hF);
        beats(129, 1'b0, 1'b0);
        wr_reg(OFF_CTRL, 32'h8);
        rd_chk(OFF_CYC,  32'd2, "R10 divided cycle count");
        rd_chk(OFF_CTRL, 32'h8, "R10 divider bit readback");

        // R9 R10 cycle counter wrap (12 bits)
        wr_reg(OFF_CTRL, 32'h7);
        beats(4095, 1'b0, 1'b0);
        wr_reg(OFF_CTRL, 32'h0);
        rd_chk(OFF_CYC,  32'd0,         "R10 cycle counter wrapped");
        rd_chk(OFF_FLAG, 32'h8000_0000, "R9 cycle flag set");

        drive(1'b0, 1'b0, '0, '0, 1'b0, 1'b0);
        repeat (4) @(negedge clk);
        if (sb.size() != 0) begin
            tests++;
            fails++;
            $display("FAIL R2 missing read data: actual %0d left expected 0", sb.size());
        end
        finish_run();
    end
endmodule